// File: doc/BRIEF.md
# Edge and Level External Interrupt Controller

This block watches a set of external interrupt lines and turns them into interrupt outputs under the control of a small register bank on a 32-bit memory-mapped bus. The lines are grouped into two banks of up to 32 bits each. Line n is held in bank n/32 at bit n%32. Each bank has its own set of six registers.

Each line has a fixed kind, set at elaboration time by a mask parameter. An edge line watches for rising and/or falling transitions. When it sees one, it latches a pending flag and raises its output for exactly one clock. A direct line has no edge logic. While it is unmasked, its output follows its input level.

Software can raise edge interrupts through a trigger register. It acknowledges them by writing ones to the pending register. A per-line event mask is stored and can be read back, but it controls nothing.

Top module: `eint_ctrl`

## Requirements
- R1: After reset, the interrupt mask of each bank holds that bank's direct-line pattern: 0xFF820000 for bank 0 (line bits 17 and 23..31) and 0x00000087 for bank 1 (lines 32, 33, 34 and 39). Every other register reads 0 and irq_out is all zero.
- R2: Each bank has six registers at these word offsets: interrupt mask +0x00, event mask +0x04, rising select +0x08, falling select +0x0C, software trigger +0x10, pending +0x14. Bank 0 starts at 0x00 and bank 1 at 0x20. Read data appears on bus_rdata one clock after the request. A write takes effect at the clock edge where it is presented.
- R3: Writes to either mask register keep only bits of existing lines, so bank 1 keeps bits 7..0. Writes to the select, trigger and pending registers keep only bits of edge lines.
- R4: An unmasked edge line sets its pending bit and pulses its irq_out bit for one cycle in two cases: on a 0-to-1 change while its rising-select bit is 1, or on a 1-to-0 change while its falling-select bit is 1. The pulse is visible in the cycle after the clock edge that samples the change.
- R5: While a line is masked, changes on it set no pending bit and do not change its output. Its last level is still recorded, so unmasking it later creates no event.
- R6: When an unmasked direct line changes, its irq_out bit takes the new level one cycle later. Its pending bit is never set.
- R7: A line whose input equals its recorded level produces no event.
- R8: A write to the software trigger register fires only the bits that meet all four conditions: written as 1, previously 0, unmasked, and not already pending. Each fired bit is set pending and pulsed on irq_out. The register then holds the written value, limited to edge-line bits.
- R9: Writing 1 to a pending bit clears that bit and the matching software trigger bit. Writing 0 changes nothing.
- R10: A read of an unmapped or unaligned address returns 0. A write to one changes nothing.
- R11: The event mask register is stored and read back, but has no effect on pending bits or outputs.
- R12: If a line event and a pending clear hit the same bit at the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| line_in | input | NUM_LINES | External lines, synchronous to clk |
| irq_out | output | NUM_LINES | Interrupt outputs (pulses for edge lines, levels for direct lines) |

## Verification
The embedded properties check on every clock the following:
- every newly set pending bit comes with a pulse, and every pulse has its pending bit set;
- no pulse comes from a line that was masked at the sampling edge;
- a direct output moves only when its recorded level moves;
- unmapped reads return zero.

Other behaviours need the bench's ordered scenarios:
- the pulse width and the direct-output latency;
- the four-way software trigger condition;
- the masking applied on writes;
- level tracking while a line is masked;
- the outcome when a line event and a pending clear collide.

// File: rtl/eint_pkg.sv
`timescale 1ns/1ps
package eint_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    RS_IMASK  = 3'd0,
    RS_EMASK  = 3'd1,
    RS_RISE   = 3'd2,
    RS_FALL   = 3'd3,
    RS_SWTRIG = 3'd4,
    RS_PEND   = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic     wr;
    logic     rd;
    logic     hit;
    reg_sel_e sel;
  } bus_cmd_t;
endpackage

// File: rtl/eint_busdec.sv
`timescale 1ns/1ps
module eint_busdec #(
  parameter int ADDR_W    = 10,
  parameter int NUM_BANKS = 2,
  parameter int BSEL_W    = 1
) (
  input  logic                 req,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  output eint_pkg::bus_cmd_t   cmd,
  output logic [BSEL_W-1:0]    bank
);
  localparam int BANK_LSB = 5;
  localparam int TOP_LSB  = BANK_LSB + BSEL_W;

  logic aligned, upper_zero, sel_ok, bank_ok;

  generate
    if (TOP_LSB < ADDR_W) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:TOP_LSB] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    bank    = addr[BANK_LSB +: BSEL_W];
    aligned = (addr[1:0] == 2'b00);
    sel_ok  = (addr[4:2] <= 3'd5);
    bank_ok = ({{(32-BSEL_W){1'b0}}, bank} < 32'(NUM_BANKS));
    cmd.hit = aligned & upper_zero & sel_ok & bank_ok;
    cmd.wr  = req & we & cmd.hit;
    cmd.rd  = req & ~we;
    cmd.sel = eint_pkg::reg_sel_e'(addr[4:2]);
  end
endmodule

// File: rtl/eint_detect.sv
`timescale 1ns/1ps
module eint_detect #(
  parameter int                   NUM_LINES   = 40,
  parameter logic [NUM_LINES-1:0] DIRECT_MASK = 40'h87_FF82_0000
) (
  input  logic [NUM_LINES-1:0] line_in,
  input  logic [NUM_LINES-1:0] lvl_q,
  input  logic [NUM_LINES-1:0] imask,
  input  logic [NUM_LINES-1:0] rise_sel,
  input  logic [NUM_LINES-1:0] fall_sel,
  output logic [NUM_LINES-1:0] hw_set,
  output logic [NUM_LINES-1:0] dir_load
);
  localparam logic [NUM_LINES-1:0] CFG_MASK = ~DIRECT_MASK;

  logic [NUM_LINES-1:0] chg, edge_hit;

  always_comb begin
    chg      = line_in ^ lvl_q;
    edge_hit = (line_in & rise_sel) | (~line_in & fall_sel);
    hw_set   = chg & imask & CFG_MASK & edge_hit;
    dir_load = chg & imask & DIRECT_MASK;
  end
endmodule

// File: rtl/eint_regs.sv
`timescale 1ns/1ps
module eint_regs #(
  parameter int                   NUM_LINES   = 40,
  parameter int                   BSEL_W      = 1,
  parameter logic [NUM_LINES-1:0] DIRECT_MASK = 40'h87_FF82_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  eint_pkg::bus_cmd_t    cmd,
  input  logic [BSEL_W-1:0]     bank,
  input  logic [31:0]           wdata,
  input  logic [NUM_LINES-1:0]  line_in,
  input  logic [NUM_LINES-1:0]  hw_set,
  input  logic [NUM_LINES-1:0]  dir_load,
  output logic [NUM_LINES-1:0]  imask_q,
  output logic [NUM_LINES-1:0]  rise_q,
  output logic [NUM_LINES-1:0]  fall_q,
  output logic [NUM_LINES-1:0]  lvl_q,
  output logic [NUM_LINES-1:0]  irq_out,
  output logic [31:0]           rdata_q
);
  import eint_pkg::*;
  localparam logic [NUM_LINES-1:0] CFG_MASK = ~DIRECT_MASK;

  logic [NUM_LINES-1:0] emask_q, swt_q, pend_q, pulse_q, dir_q;
  logic [NUM_LINES-1:0] imask_d, emask_d, rise_d, fall_d, swt_d, pend_d, pulse_d, dir_d;
  logic [NUM_LINES-1:0] in_bank, wd_spread, wr_cfg, sw_fire, clr, sel_vec;
  logic [31:0]          rd_word, rdata_d;
  logic                 rd_en;

  // Spread the bus word over the addressed bank
  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      in_bank[i]   = (bank == BSEL_W'(i / 32));
      wd_spread[i] = wdata[i % 32];
    end
    wr_cfg = wd_spread & in_bank & CFG_MASK;
  end

  // Next state
  always_comb begin
    imask_d = imask_q;
    emask_d = emask_q;
    rise_d  = rise_q;
    fall_d  = fall_q;
    swt_d   = swt_q;
    sw_fire = '0;
    clr     = '0;
    if (cmd.wr) begin
      case (cmd.sel)
        RS_IMASK:  imask_d = (imask_q & ~in_bank) | (wd_spread & in_bank);
        RS_EMASK:  emask_d = (emask_q & ~in_bank) | (wd_spread & in_bank);
        RS_RISE:   rise_d  = (rise_q & ~in_bank) | wr_cfg;
        RS_FALL:   fall_d  = (fall_q & ~in_bank) | wr_cfg;
        RS_SWTRIG: begin
          sw_fire = wr_cfg & ~swt_q & imask_q & ~pend_q;
          swt_d   = (swt_q & ~in_bank) | wr_cfg;
        end
        RS_PEND: begin
          clr   = pend_q & wr_cfg;
          swt_d = swt_q & ~clr;
        end
        default: ;
      endcase
    end
    // a line event in the same cycle as a clear keeps the bit set (R12)
    pend_d  = (pend_q & ~clr) | hw_set | sw_fire;
    pulse_d = hw_set | sw_fire;
    dir_d   = (dir_q & ~dir_load) | (line_in & dir_load);
  end

  // Read path
  always_comb begin
    case (cmd.sel)
      RS_IMASK:  sel_vec = imask_q;
      RS_EMASK:  sel_vec = emask_q;
      RS_RISE:   sel_vec = rise_q;
      RS_FALL:   sel_vec = fall_q;
      RS_SWTRIG: sel_vec = swt_q;
      RS_PEND:   sel_vec = pend_q;
      default:   sel_vec = '0;
    endcase
    rd_word = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (in_bank[i]) rd_word[i % 32] = sel_vec[i];
    end
    rdata_d = cmd.hit ? rd_word : '0;
    rd_en   = cmd.rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q <= DIRECT_MASK;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      swt_q   <= '0;
      pend_q  <= '0;
      pulse_q <= '0;
      dir_q   <= '0;
      lvl_q   <= '0;
      rdata_q <= '0;
    end else begin
      imask_q <= imask_d;
      emask_q <= emask_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      swt_q   <= swt_d;
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
      dir_q   <= dir_d;
      lvl_q   <= line_in;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign irq_out = pulse_q | dir_q;

  assert_pend_needs_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~pulse_q) == '0));

  assert_masked_no_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pulse_q & ~$past(imask_q)) == '0));

  assert_direct_follows_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((dir_q ^ $past(dir_q)) & ~(lvl_q ^ $past(lvl_q))) == '0));

  assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.rd && !cmd.hit) |=> (rdata_q == '0));

  assert_pulse_has_pend_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((pulse_q & ~pend_q) == '0));
endmodule

// File: rtl/eint_ctrl.sv
`timescale 1ns/1ps
module eint_ctrl #(
  parameter int                   NUM_LINES   = 40,
  parameter int                   ADDR_W      = 10,
  parameter logic [NUM_LINES-1:0] DIRECT_MASK = 40'h87_FF82_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] line_in,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam int NUM_BANKS = (NUM_LINES + 31) / 32;
  localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [1:0]           rst_pipe;
  logic                 rst_int_n;
  eint_pkg::bus_cmd_t   cmd;
  logic [BSEL_W-1:0]    bank;
  logic [NUM_LINES-1:0] imask_q, rise_q, fall_q, lvl_q, hw_set, dir_load;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  eint_busdec #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BSEL_W(BSEL_W)) u_busdec (
    .req(bus_req), .we(bus_we), .addr(bus_addr), .cmd(cmd), .bank(bank)
  );

  eint_detect #(.NUM_LINES(NUM_LINES), .DIRECT_MASK(DIRECT_MASK)) u_detect (
    .line_in(line_in), .lvl_q(lvl_q), .imask(imask_q), .rise_sel(rise_q),
    .fall_sel(fall_q), .hw_set(hw_set), .dir_load(dir_load)
  );

  eint_regs #(.NUM_LINES(NUM_LINES), .BSEL_W(BSEL_W), .DIRECT_MASK(DIRECT_MASK)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .cmd(cmd), .bank(bank), .wdata(bus_wdata),
    .line_in(line_in), .hw_set(hw_set), .dir_load(dir_load),
    .imask_q(imask_q), .rise_q(rise_q), .fall_q(fall_q), .lvl_q(lvl_q),
    .irq_out(irq_out), .rdata_q(bus_rdata)
  );
endmodule

// File: tb/eint_ctrl_bench.sv
`timescale 1ns/1ps
module eint_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [39:0] line_in, irq_out;
  logic [39:0] lines;
  logic [31:0] rd;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eint_ctrl u_eint_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_in(line_in), .irq_out(irq_out)
  );

  typedef struct packed {
    logic        we;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 27;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 10'h000, 32'h0, 32'hFF82_0000, 8'd1},
    '{1'b0, 10'h020, 32'h0, 32'h0000_0087, 8'd1},
    '{1'b0, 10'h014, 32'h0, 32'h0, 8'd1},
    '{1'b0, 10'h034, 32'h0, 32'h0, 8'd1},
    '{1'b1, 10'h000, 32'hFFFF_FFFF, 32'h0, 8'd3},
    '{1'b0, 10'h000, 32'h0, 32'hFFFF_FFFF, 8'd3},
    '{1'b1, 10'h020, 32'hFFFF_FFFF, 32'h0, 8'd3},
    '{1'b0, 10'h020, 32'h0, 32'h0000_00FF, 8'd3},
    '{1'b1, 10'h008, 32'hFFFF_FFFF, 32'h0, 8'd3},
    '{1'b0, 10'h008, 32'h0, 32'h007D_FFFF, 8'd3},
    '{1'b1, 10'h028, 32'hFFFF_FFFF, 32'h0, 8'd3},
    '{1'b0, 10'h028, 32'h0, 32'h0000_0078, 8'd3},
    '{1'b1, 10'h034, 32'hFFFF_FFFF, 32'h0, 8'd9},
    '{1'b0, 10'h034, 32'h0, 32'h0, 8'd9},
    '{1'b1, 10'h024, 32'hFFFF_FFFF, 32'h0, 8'd11},
    '{1'b0, 10'h024, 32'h0, 32'h0000_00FF, 8'd11},
    '{1'b0, 10'h018, 32'h0, 32'h0, 8'd10},
    '{1'b0, 10'h002, 32'h0, 32'h0, 8'd10},
    '{1'b1, 10'h040, 32'h0, 32'h0, 8'd10},
    '{1'b0, 10'h000, 32'h0, 32'hFFFF_FFFF, 8'd10},
    '{1'b1, 10'h048, 32'h0, 32'h0, 8'd10},
    '{1'b0, 10'h008, 32'h0, 32'h007D_FFFF, 8'd10},
    '{1'b1, 10'h008, 32'h0, 32'h0, 8'd2},
    '{1'b1, 10'h028, 32'h0, 32'h0, 8'd2},
    '{1'b0, 10'h028, 32'h0, 32'h0, 8'd2},
    '{1'b1, 10'h004, 32'h0000_000F, 32'h0, 8'd2},
    '{1'b0, 10'h004, 32'h0, 32'h0000_000F, 8'd2}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic line_step(input int idx, input logic val);
    @(negedge clk);
    lines[idx] = val;
    line_in = lines;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    lines = '0; line_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 irq_out after reset", {24'h0, irq_out}, 64'h0);

    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].we) bus_write(VECS[v].addr, VECS[v].data);
      else begin
        bus_read(VECS[v].addr, rd);
        check($sformatf("R%0d table vector %0d", VECS[v].req, v), {32'h0, rd}, {32'h0, VECS[v].exp});
      end
    end

    // R4 rising edge pulse, one cycle wide
    bus_write(10'h008, 32'h1);
    line_step(0, 1'b1);
    check("R4 rise pulse", {24'h0, irq_out}, 64'h1);
    @(negedge clk);
    check("R4 pulse lasts one cycle", {24'h0, irq_out}, 64'h0);
    bus_read(10'h014, rd); check("R4 pending set", {32'h0, rd}, 64'h1);

    // R9 write-one-to-clear
    bus_write(10'h014, 32'h0);
    bus_read(10'h014, rd); check("R9 zero write keeps pend", {32'h0, rd}, 64'h1);
    bus_write(10'h014, 32'h1);
    bus_read(10'h014, rd); check("R9 one write clears pend", {32'h0, rd}, 64'h0);

    // R4 falling edges
    line_step(0, 1'b0);
    check("R4 fall ignored without select", {24'h0, irq_out}, 64'h0);
    bus_read(10'h014, rd); check("R4 no pend on unselected fall", {32'h0, rd}, 64'h0);
    bus_write(10'h00C, 32'h1);
    line_step(0, 1'b1);
    check("R4 rise pulse again", {24'h0, irq_out}, 64'h1);
    bus_write(10'h014, 32'h1);
    line_step(0, 1'b0);
    check("R4 fall pulse", {24'h0, irq_out}, 64'h1);
    bus_write(10'h014, 32'h1);

    // R7 unchanged level
    line_step(0, 1'b0);
    check("R7 steady line no event", {24'h0, irq_out}, 64'h0);

    // R5 masked line still tracks level
    bus_write(10'h000, 32'hFFFF_FFFE);
    line_step(0, 1'b1);
    check("R5 masked rise no pulse", {24'h0, irq_out}, 64'h0);
    bus_read(10'h014, rd); check("R5 masked rise no pend", {32'h0, rd}, 64'h0);
    bus_write(10'h000, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R5 unmask no spurious event", {24'h0, irq_out}, 64'h0);
    line_step(0, 1'b0);
    check("R5 fall after unmask detected", {24'h0, irq_out}, 64'h1);
    bus_write(10'h014, 32'h1);

    // R6 direct lines
    line_step(17, 1'b1);
    check("R6 direct line 17 high", {24'h0, irq_out}, 64'h0_0002_0000);
    bus_read(10'h014, rd); check("R6 direct leaves pend clear", {32'h0, rd}, 64'h0);
    line_step(39, 1'b1);
    check("R6 direct line 39 high", {24'h0, irq_out}, 64'h80_0002_0000);
    bus_write(10'h020, 32'h7F);
    line_step(39, 1'b0);
    check("R5 masked direct holds output", {24'h0, irq_out}, 64'h80_0002_0000);
    line_step(17, 1'b0);
    check("R6 direct line 17 low", {24'h0, irq_out}, 64'h80_0000_0000);

    // R11 event mask has no effect
    line_step(1, 1'b1);
    check("R11 event mask raises nothing", {24'h0, irq_out}, 64'h80_0000_0000);
    line_step(1, 1'b0);
    check("R11 event mask fall nothing", {24'h0, irq_out}, 64'h80_0000_0000);

    // R8 software trigger
    bus_write(10'h010, 32'h4);
    check("R8 trigger pulse", {24'h0, irq_out}, 64'h80_0000_0004);
    @(negedge clk);
    check("R8 trigger pulse one cycle", {24'h0, irq_out}, 64'h80_0000_0000);
    bus_read(10'h014, rd); check("R8 trigger sets pend", {32'h0, rd}, 64'h4);
    bus_read(10'h010, rd); check("R8 trigger reg value", {32'h0, rd}, 64'h4);
    bus_write(10'h010, 32'h4);
    check("R8 repeated one no pulse", {24'h0, irq_out}, 64'h80_0000_0000);
    bus_write(10'h010, 32'h0);
    bus_write(10'h010, 32'h4);
    check("R8 already pending no pulse", {24'h0, irq_out}, 64'h80_0000_0000);
    bus_write(10'h014, 32'h4);
    bus_read(10'h014, rd); check("R9 clear pend", {32'h0, rd}, 64'h0);
    bus_read(10'h010, rd); check("R9 clear also clears trigger", {32'h0, rd}, 64'h0);
    bus_write(10'h000, 32'hFFFF_FFF7);
    bus_write(10'h010, 32'h8);
    check("R8 masked trigger no pulse", {24'h0, irq_out}, 64'h80_0000_0000);
    bus_read(10'h014, rd); check("R8 masked trigger no pend", {32'h0, rd}, 64'h0);
    bus_read(10'h010, rd); check("R8 masked trigger stored", {32'h0, rd}, 64'h8);
    bus_write(10'h010, 32'h0002_0000);
    bus_read(10'h010, rd); check("R3 trigger drops direct bit", {32'h0, rd}, 64'h0);
    bus_write(10'h000, 32'hFFFF_FFFF);

    // R12 event and clear at the same edge
    bus_write(10'h008, 32'h10);
    bus_write(10'h010, 32'h10);
    @(negedge clk);
    lines[4] = 1'b1; line_in = lines;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'h014; bus_wdata = 32'h10;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    check("R12 collision pulse", {24'h0, irq_out}, 64'h80_0000_0010);
    bus_read(10'h014, rd); check("R12 set wins over clear", {32'h0, rd}, 64'h10);
    bus_read(10'h010, rd); check("R9 collision clears trigger", {32'h0, rd}, 64'h0);
    bus_write(10'h014, 32'h10);

    // R2 bank 1 edge line 35
    bus_write(10'h028, 32'h08);
    line_step(35, 1'b1);
    check("R2 bank1 line 35 pulse", {24'h0, irq_out}, 64'h88_0000_0000);
    bus_read(10'h034, rd); check("R2 bank1 pend bit 3", {32'h0, rd}, 64'h8);
    bus_read(10'h014, rd); check("R2 bank0 pend untouched", {32'h0, rd}, 64'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule